// File: doc/BRIEF.md
# TLP Word-Pair Deframer

The deframer takes a host stream of 32-bit words in which every payload dword is followed by a control dword. The control dword tells the block what to do with the payload in front of it. The payload can be a dword inside a TLP, the final dword of a TLP, a keep-alive filler, or an unknown code. The block rebuilds each TLP as an output stream with a last marker. It byte-swaps every payload dword from the big-endian order the host sends into the output order.

A TLP is held in an internal buffer until its final dword has arrived, and only then is it released. This lets the block discard a partial TLP completely when the TLP grows too long or when the pair framing is lost. A TLP that would exceed the maximum length is dropped, and a sticky error flag records the event. A control dword without the tag byte resynchronises the pair framing. The input stalls through a ready signal when the buffer is full. The output follows a valid/ready handshake and holds its word while it is stalled.

Top module: `tlp_pair_deframer`

## Requirements
- R1: After reset the first accepted word is a payload and words then alternate payload, control. A control dword 0x77000000 appends the preceding payload to the TLP under construction, not marked last.
- R2: A control dword 0x77040000 appends the preceding payload with `m_tlast`=1 and releases the whole TLP on the output in arrival order.
- R3: With SWAP_BYTES=1, output byte k (bits 8k+7..8k) equals payload byte 3-k, so payload 0x11223344 leaves as 0x44332211.
- R4: A pair with payload 0xFFEEDDCC and control 0x77020000 is a keep-alive. It adds nothing to the output and leaves any partial TLP intact.
- R5: A control dword whose top byte (bits 31..24) is 0x77 but which carries any other code is ignored, together with its payload. This includes 0x77020000 after any payload other than 0xFFEEDDCC. The partial TLP stays intact.
- R6: No dword of a TLP appears on the output before the pair carrying its last marker has been accepted.
- R7: A TLP of exactly MAX_TLP_DW (36) dwords passes. When dword number 36 arrives with a not-last code, the whole TLP is dropped and `oversize_err` is set. Every further pair up to and including the next last-marked pair is discarded.
- R8: `oversize_err` stays at 1 until reset.
- R9: A control dword whose top byte is not 0x77 discards the partial TLP, ends any discard started under R7, and makes the next word a payload.
- R10: While `m_tvalid`=1 and `m_tready`=0, `m_tdata` and `m_tlast` hold. `in_ready` falls when the buffer is full, and no accepted dword is lost.
- R11: After reset, `m_tvalid`=0, `oversize_err`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Host word, payload or control by position |
| in_valid | input | 1 | Host word present |
| in_ready | output | 1 | Block accepts the host word this cycle |
| m_tdata | output | 32 | Output TLP dword |
| m_tvalid | output | 1 | Output dword present |
| m_tready | input | 1 | Consumer accepts the output dword |
| m_tlast | output | 1 | Final dword of a TLP |
| oversize_err | output | 1 | Sticky: a TLP was dropped for length |

## Verification
The write side can rewind its pointer while the read side pops a committed dword in the same cycle. A rewind comes from an oversize drop or a resync, and a pop drains the earlier TLP. The bench provokes this by following a complete TLP at once with an overlong or broken one while `m_tready` toggles pseudo-randomly. The bench judges the result by comparing every output dword and last flag against a queue built from the requirements: the earlier TLP must arrive whole and the dropped one must leave no trace. A second overlap fills the buffer while the output is held off. The bench then checks that `in_ready` is low, that the held word is stable, and that every dword arrives after release.

// File: rtl/tlpd_pkg.sv
package tlpd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0]  CTL_TAG      = 8'h77;
  localparam logic [23:0] CODE_MID     = 24'h000000;
  localparam logic [23:0] CODE_END     = 24'h040000;
  localparam logic [23:0] CODE_IDLE    = 24'h020000;
  localparam logic [31:0] IDLE_PAYLOAD = 32'hFFEEDDCC;

  typedef enum logic [2:0] {
    KIND_MID,
    KIND_END,
    KIND_IDLE,
    KIND_SKIP,
    KIND_RESYNC
  } ctl_kind_e;
endpackage

// File: rtl/tlpd_ctl_decode.sv
module tlpd_ctl_decode
  import tlpd_pkg::*;
(
  input  logic [WORD_W-1:0] payload,
  input  logic [WORD_W-1:0] ctl,
  output ctl_kind_e         kind
);
  always_comb begin
    if (ctl[31:24] != CTL_TAG)
      kind = KIND_RESYNC;
    else if (ctl[23:0] == CODE_MID)
      kind = KIND_MID;
    else if (ctl[23:0] == CODE_END)
      kind = KIND_END;
    else if (ctl[23:0] == CODE_IDLE && payload == IDLE_PAYLOAD)
      kind = KIND_IDLE;
    else
      kind = KIND_SKIP;
  end
endmodule

// File: rtl/tlpd_assembler.sv
module tlpd_assembler
  import tlpd_pkg::*;
#(
  parameter int unsigned MAX_TLP_DW = 36,
  parameter bit          SWAP_BYTES = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_ready,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_last,
  output logic              drop,
  output logic              err
);
  localparam int unsigned CNT_W = $clog2(MAX_TLP_DW + 1);
  localparam int unsigned NBYTE = WORD_W / 8;

  logic              at_ctl;
  logic [WORD_W-1:0] held;
  logic [CNT_W-1:0]  cnt;
  logic              skipping;
  logic              accept;
  logic              set_skip, clr_skip;
  ctl_kind_e         kind;

  assign accept = in_valid && in_ready;

  tlpd_ctl_decode u_dec (
    .payload (held),
    .ctl     (in_data),
    .kind    (kind)
  );

  generate
    if (SWAP_BYTES) begin : g_swap
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign wr_data[8*b +: 8] = held[WORD_W-1-8*b -: 8];
      end
    end else begin : g_keep
      assign wr_data = held;
    end
  endgenerate

  always_comb begin
    wr_en    = 1'b0;
    wr_last  = 1'b0;
    drop     = 1'b0;
    set_skip = 1'b0;
    clr_skip = 1'b0;
    if (accept && at_ctl) begin
      unique case (kind)
        KIND_MID: begin
          if (!skipping) begin
            if (cnt == CNT_W'(MAX_TLP_DW - 1)) begin
              drop     = 1'b1;
              set_skip = 1'b1;
            end else begin
              wr_en = 1'b1;
            end
          end
        end
        KIND_END: begin
          if (skipping) begin
            clr_skip = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_last = 1'b1;
          end
        end
        KIND_RESYNC: begin
          drop     = 1'b1;
          clr_skip = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      at_ctl   <= 1'b0;
      held     <= '0;
      cnt      <= '0;
      skipping <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (accept) at_ctl <= !at_ctl;
      if (accept && !at_ctl) held <= in_data;
      if (drop || (wr_en && wr_last)) cnt <= '0;
      else if (wr_en) cnt <= cnt + 1'b1;
      if (set_skip) begin
        skipping <= 1'b1;
        err      <= 1'b1;
      end else if (clr_skip) begin
        skipping <= 1'b0;
      end
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_TLP_DW));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  assert_skip_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    skipping |-> !(wr_en && !wr_last));
  assert_payload_nowrite_R1: assert property (@(posedge clk) disable iff (rst)
    !at_ctl |-> !wr_en && !drop);
endmodule

// File: rtl/tlpd_store.sv
module tlpd_store
  import tlpd_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              drop,
  output logic              space_ok,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WORD_W:0] mem [DEPTH];
  logic [AW:0]     wr_ptr, cm_ptr, rd_ptr;
  logic [AW:0]     used;
  logic            load;

  assign used     = wr_ptr - rd_ptr;
  assign space_ok = used < (AW+1)'(DEPTH);
  assign load     = (rd_ptr != cm_ptr) && (!m_tvalid || m_tready);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      cm_ptr   <= '0;
      rd_ptr   <= '0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else begin
      if (drop) begin
        wr_ptr <= cm_ptr;
      end else if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (wr_last) cm_ptr <= wr_ptr + 1'b1;
      end
      if (load) begin
        {m_tlast, m_tdata} <= mem[rd_ptr[AW-1:0]];
        m_tvalid <= 1'b1;
        rd_ptr   <= rd_ptr + 1'b1;
      end else if (m_tready) begin
        m_tvalid <= 1'b0;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> used < (AW+1)'(DEPTH));
  assert_drop_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(drop && wr_en));
  assert_commit_only_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr - cm_ptr) == '0 || (cm_ptr - rd_ptr) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/tlp_pair_deframer.sv
module tlp_pair_deframer
  import tlpd_pkg::*;
#(
  parameter int unsigned MAX_TLP_DW = 36,
  parameter int unsigned BUF_DEPTH  = 64,
  parameter bit          SWAP_BYTES = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        oversize_err
);
  logic              wr_en, wr_last, drop;
  logic [WORD_W-1:0] wr_data;

  initial begin
    if (BUF_DEPTH < MAX_TLP_DW || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0)
      $error("BUF_DEPTH must be a power of two and hold a full TLP");
  end

  tlpd_assembler #(
    .MAX_TLP_DW (MAX_TLP_DW),
    .SWAP_BYTES (SWAP_BYTES)
  ) u_asm (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_last  (wr_last),
    .drop     (drop),
    .err      (oversize_err)
  );

  tlpd_store #(
    .DEPTH (BUF_DEPTH)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_last  (wr_last),
    .drop     (drop),
    .space_ok (in_ready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tready (m_tready)
  );
endmodule

// File: tb/tlp_pair_deframer_test.sv
module tlp_pair_deframer_test;
  localparam int MAXD = 36;
  localparam logic [31:0] C_MID  = 32'h77000000;
  localparam logic [31:0] C_END  = 32'h77040000;
  localparam logic [31:0] C_IDLE = 32'h77020000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tlast;
  logic        oversize_err;

  int errors = 0;
  int checks = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_d[$];
  logic        exp_l[$];
  bit          done = 0;

  always #2 clk = !clk;

  tlp_pair_deframer uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .oversize_err(oversize_err)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] pay(input int tag, input int i);
    return (32'(tag) << 24) ^ (32'(i) * 32'h00010305) ^ 32'h00A05000;
  endfunction

  // output side: choose tready, then record the transfer of the coming edge
  always @(negedge clk) begin
    if (!rst) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_tready = (bp_mode == 0) ? 1'b1 : (bp_mode == 2) ? 1'b0 : lfsr[0];
      if (m_tvalid && m_tready) begin
        if (exp_d.size() == 0) begin
          chk(0, "R6 unexpected output dword", m_tdata, 32'h0);
        end else begin
          chk(m_tdata == exp_d[0], "R1/R3 stream dword", m_tdata, exp_d[0]);
          chk(m_tlast == exp_l[0], "R2 last flag", 32'(m_tlast), 32'(exp_l[0]));
          void'(exp_d.pop_front());
          void'(exp_l.pop_front());
        end
      end
    end
  end

  task automatic send_word(input logic [31:0] d);
    in_data = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pair(input logic [31:0] p, input logic [31:0] c);
    send_word(p);
    send_word(c);
  endtask

  // n dwords, last marker on the final one, expected output queued
  task automatic send_tlp(input int tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_d.push_back(bswap(pay(tag, i)));
      exp_l.push_back(i == n - 1);
    end
    for (int i = 0; i < n; i++) send_pair(pay(tag, i), (i == n - 1) ? C_END : C_MID);
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && exp_d.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(m_tvalid == 0, "R11 tvalid after reset", 32'(m_tvalid), 0);
    chk(oversize_err == 0, "R11 err after reset", 32'(oversize_err), 0);
    chk(in_ready == 1, "R11 in_ready after reset", 32'(in_ready), 1);

    // R3 single dword byte order
    exp_d.push_back(32'h44332211); exp_l.push_back(1'b1);
    send_pair(32'h11223344, C_END);
    drain();
    chk(exp_d.size() == 0, "R3 single dword delivered", 32'(exp_d.size()), 0);

    // R6 nothing out before the last marker
    for (int i = 0; i < 5; i++) send_pair(pay(9, i), C_MID);
    repeat (12) @(negedge clk);
    chk(m_tvalid == 0, "R6 held until last", 32'(m_tvalid), 0);
    for (int i = 0; i < 5; i++) begin
      exp_d.push_back(bswap(pay(9, i))); exp_l.push_back(i == 5);
    end
    exp_d.push_back(bswap(pay(9, 5))); exp_l.push_back(1'b1);
    send_pair(pay(9, 5), C_END);
    drain();

    // R1 R2 R7 sweep of every legal length, random backpressure
    bp_mode = 1;
    for (int n = 1; n <= MAXD; n++) send_tlp(n, n);
    drain();
    chk(exp_d.size() == 0, "R2 sweep delivered", 32'(exp_d.size()), 0);
    chk(oversize_err == 0, "R7 no error at 36 dwords", 32'(oversize_err), 0);

    // R4 keep-alive and R5 ignored codes inside a TLP
    exp_d.push_back(bswap(pay(50, 0))); exp_l.push_back(1'b0);
    exp_d.push_back(bswap(pay(50, 1))); exp_l.push_back(1'b0);
    exp_d.push_back(bswap(pay(50, 2))); exp_l.push_back(1'b1);
    send_pair(pay(50, 0), C_MID);
    send_pair(32'hFFEEDDCC, C_IDLE);
    send_pair(pay(50, 1), C_MID);
    send_pair(32'h12345678, C_IDLE);
    send_pair(32'hCAFEF00D, 32'h77010000);
    send_pair(32'hFFEEDDCC, C_IDLE);
    send_pair(pay(50, 2), C_END);
    drain();
    chk(exp_d.size() == 0, "R4/R5 partial TLP intact", 32'(exp_d.size()), 0);

    // R9 resync discards partial, behind a committed TLP
    send_tlp(60, 7);
    for (int i = 0; i < 3; i++) send_pair(pay(61, i), C_MID);
    send_pair(pay(61, 3), 32'h12000000);
    send_tlp(62, 2);
    drain();
    chk(exp_d.size() == 0, "R9 resync stream", 32'(exp_d.size()), 0);
    chk(oversize_err == 0, "R9 resync sets no error", 32'(oversize_err), 0);

    // R7 oversize drop behind a committed TLP
    send_tlp(70, 20);
    for (int i = 0; i < MAXD; i++) send_pair(pay(71, i), C_MID);
    for (int i = 0; i < 3; i++) send_pair(pay(72, i), C_MID);
    send_pair(pay(72, 3), C_END);
    send_tlp(73, 4);
    drain();
    chk(exp_d.size() == 0, "R7 oversize dropped", 32'(exp_d.size()), 0);
    chk(oversize_err == 1, "R7 error set", 32'(oversize_err), 1);

    // R9 resync ends an oversize discard
    for (int i = 0; i < MAXD + 2; i++) send_pair(pay(80, i), C_MID);
    send_pair(pay(80, 99), 32'h00000000);
    send_tlp(81, 3);
    drain();
    chk(exp_d.size() == 0, "R9 resync ends discard", 32'(exp_d.size()), 0);
    chk(oversize_err == 1, "R8 error sticky", 32'(oversize_err), 1);

    // R10 full buffer under held-off output
    bp_mode = 2;
    fork
      begin
        send_tlp(90, 30); send_tlp(91, 30); send_tlp(92, 30);
      end
      begin
        logic [31:0] snap;
        repeat (400) @(negedge clk);
        chk(in_ready == 0, "R10 in_ready low when full", 32'(in_ready), 0);
        chk(m_tvalid == 1, "R10 word waiting", 32'(m_tvalid), 1);
        snap = m_tdata;
        repeat (6) @(negedge clk);
        chk(m_tdata == snap, "R10 data held", m_tdata, snap);
        bp_mode = 1;
      end
    join
    drain();
    chk(exp_d.size() == 0, "R10 nothing lost", 32'(exp_d.size()), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule